// File: doc/BRIEF.md
# Dual-Rail Threshold Gate with Hysteresis

This block is a bank of dual-rail logic elements for three-valued signalling. Each value is carried on two rails and is either NULL, TRUE or FALSE. Every lane takes two dual-rail operands, `a` and `b`. The lane computes AND, OR or NOT on them; a parameter picks the function at build time. A lane does not follow its inputs freely. From NULL it moves to a data result only once every operand it uses carries data. From a data value it returns to NULL only once every operand it uses is NULL. In every other case it keeps the value it already has.

This hold is what lets waves of data and NULL pace each other through a chain of such elements. A partial data set from a slow operand cannot produce a result early. A data operand that arrives ahead of the NULL separator cannot overwrite the last result. Each lane keeps its state in a clocked register that reset clears to NULL. The value a lane will take next therefore depends on its operands and on its own current value.

Completeness is carried by the rail encoding itself, so the block has no valid/ready handshake. Each output is meaningful whenever it is not NULL. A consumer knows a new result has arrived when the lane's hold flag rises, and knows it has been withdrawn when the flag falls. A rail pair with both rails high is never a legal value. Such an input is treated as incomplete, and the block reports it on an error pin one cycle later.

Top module: `ncl_hyst_gate`

## Requirements
- R1: Each dual-rail value is two bits, with 2'b00 = NULL, 2'b01 = TRUE, 2'b10 = FALSE and 2'b11 = illegal. Lane i occupies bits [2i+1:2i] of every rail bus.
- R2: While `rst_n` is low, every lane output is NULL, `y_hold` is all zero and `err` is 0, whatever the inputs are.
- R3: With FN = FN_AND, a lane that leaves NULL takes TRUE only when both operands are TRUE, and FALSE for any other pair of data operands.
- R4: With FN = FN_OR, a lane that leaves NULL takes FALSE only when both operands are FALSE, and TRUE for any other pair of data operands.
- R5: With FN = FN_NOT, a lane takes FALSE for a TRUE `a`, TRUE for a FALSE `a`, and returns to NULL for a NULL `a`. The `b` operand, including an illegal `b`, has no effect on the output or on `err`.
- R6: A lane at NULL stays NULL for as long as any operand it uses is not data.
- R7: A lane at a data value keeps that exact value until every operand it uses is NULL. New data arriving without a NULL in between leaves the output unchanged.
- R8: An output changes only at the rising clock edge that samples the complete operand set, one cycle after the inputs are applied.
- R9: A 2'b11 on any used operand counts as neither data nor NULL, so the lane holds. `err` is 1 in the cycle after any such operand is sampled, and 0 after a cycle with none.
- R10: Lanes are independent: the operands of one lane never change another lane's output.
- R11: `y_hold[i]` is 1 exactly while lane i holds a data value, and 0 while it is NULL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the state registers |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_rails | input | 2*LANES | First operand of every lane, dual-rail |
| b_rails | input | 2*LANES | Second operand of every lane, dual-rail (unused for NOT) |
| y_rails | output | 2*LANES | Held output of every lane, dual-rail |
| y_hold | output | LANES | Per-lane flag, 1 while the lane holds data |
| err | output | 1 | An illegal rail pair was sampled in the previous cycle |

## Verification
The bench builds three copies of the block: FN_AND with two lanes, FN_OR with two lanes, and FN_NOT with one lane. The AND and OR copies receive the same operand sequence, so one table checks both truth tables and their shared hold behaviour. The second lane of each of those copies stays quiet while the first lane is exercised, and is then driven against it, which makes lane independence observable. The one-lane NOT copy is where an illegal or changing `b` operand can be shown to have no effect.

// File: rtl/ncl_gate_pkg.sv
package ncl_gate_pkg;

  typedef logic [1:0] dr_t;

  localparam dr_t DR_NULL  = 2'b00;
  localparam dr_t DR_TRUE  = 2'b01;
  localparam dr_t DR_FALSE = 2'b10;
  localparam dr_t DR_BAD   = 2'b11;

  typedef enum logic [1:0] {
    FN_AND = 2'd0,
    FN_OR  = 2'd1,
    FN_NOT = 2'd2
  } gate_fn_e;

  typedef struct packed {
    logic is_null;
    logic is_data;
    logic is_bad;
    logic val;
  } dr_class_t;

endpackage

// File: rtl/ncl_rail_decode.sv
module ncl_rail_decode
  import ncl_gate_pkg::*;
(
  input  dr_t       rails,
  output dr_class_t cls
);

  always_comb begin
    cls = '0;
    unique case (rails)
      DR_NULL:  cls.is_null = 1'b1;
      DR_TRUE:  begin cls.is_data = 1'b1; cls.val = 1'b1; end
      DR_FALSE: cls.is_data = 1'b1;
      default:  cls.is_bad  = 1'b1;
    endcase
  end

endmodule

// File: rtl/ncl_func_eval.sv
module ncl_func_eval
  import ncl_gate_pkg::*;
#(
  parameter gate_fn_e FN = FN_AND
) (
  input  dr_class_t cls_a,
  input  dr_class_t cls_b,
  output logic      all_data,
  output logic      all_null,
  output logic      any_bad,
  output dr_t       result
);

  generate
    if (FN == FN_NOT) begin : g_not
      logic unused_b;
      assign unused_b = ^cls_b;
      assign all_data = cls_a.is_data;
      assign all_null = cls_a.is_null;
      assign any_bad  = cls_a.is_bad;
      assign result   = cls_a.val ? DR_FALSE : DR_TRUE;
    end else begin : g_two
      logic bit_res;
      assign all_data = cls_a.is_data & cls_b.is_data;
      assign all_null = cls_a.is_null & cls_b.is_null;
      assign any_bad  = cls_a.is_bad | cls_b.is_bad;
      if (FN == FN_OR) begin : g_or
        assign bit_res = cls_a.val | cls_b.val;
      end else begin : g_and
        assign bit_res = cls_a.val & cls_b.val;
      end
      assign result = bit_res ? DR_TRUE : DR_FALSE;
    end
  endgenerate

endmodule

// File: rtl/ncl_lane.sv
module ncl_lane
  import ncl_gate_pkg::*;
#(
  parameter gate_fn_e FN = FN_AND
) (
  input  logic clk,
  input  logic rst_n,
  input  dr_t  a,
  input  dr_t  b,
  output dr_t  y,
  output logic hold,
  output logic err
);

  dr_class_t cls [2];
  dr_t       opnd [2];
  logic      all_data, all_null, any_bad;
  dr_t       res, y_q, y_d;
  logic      err_q;

  assign opnd[0] = a;
  assign opnd[1] = b;

  generate
    for (genvar k = 0; k < 2; k++) begin : g_dec
      ncl_rail_decode u_dec (.rails(opnd[k]), .cls(cls[k]));
    end
  endgenerate

  ncl_func_eval #(.FN(FN)) u_eval (
    .cls_a(cls[0]), .cls_b(cls[1]),
    .all_data(all_data), .all_null(all_null),
    .any_bad(any_bad), .result(res)
  );

  always_comb begin
    y_d = y_q;
    if (y_q == DR_NULL) begin
      if (all_data) y_d = res;
    end else if (all_null) begin
      y_d = DR_NULL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q   <= DR_NULL;
      err_q <= 1'b0;
    end else begin
      y_q   <= y_d;
      err_q <= any_bad;
    end
  end

  assign y    = y_q;
  assign hold = (y_q != DR_NULL);
  assign err  = err_q;

  // R1
  no_illegal_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    y_q != DR_BAD);

  // R6
  null_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (y_q == DR_NULL && !all_data) |=> (y_q == DR_NULL));

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (y_q != DR_NULL && !all_null) |=> $stable(y_q));

  // R7
  data_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (y_q != DR_NULL && all_null) |=> (y_q == DR_NULL));

  // R9
  bad_input_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_bad |=> err_q);

endmodule

// File: rtl/ncl_hyst_gate.sv
module ncl_hyst_gate
  import ncl_gate_pkg::*;
#(
  parameter gate_fn_e FN    = FN_AND,
  parameter int       LANES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*LANES-1:0] a_rails,
  input  logic [2*LANES-1:0] b_rails,
  output logic [2*LANES-1:0] y_rails,
  output logic [LANES-1:0]   y_hold,
  output logic               err
);

  localparam int RW = 2 * LANES;

  logic [LANES-1:0] lane_err;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      ncl_lane #(.FN(FN)) u_lane (
        .clk  (clk),
        .rst_n(rst_n),
        .a    (a_rails[2*i +: 2]),
        .b    (b_rails[2*i +: 2]),
        .y    (y_rails[2*i +: 2]),
        .hold (y_hold[i]),
        .err  (lane_err[i])
      );
    end
  endgenerate

  assign err = |lane_err;

  // R2
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (y_rails == {RW{1'b0}} && !err));

endmodule

// File: tb/ncl_hyst_gate_bench.sv
module ncl_hyst_gate_bench;
  import ncl_gate_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [3:0] a2 = '0, b2 = '0;
  logic [3:0] y_and, y_or;
  logic [1:0] h_and, h_or;
  logic       e_and, e_or;
  logic [1:0] a1 = '0, b1 = '0, y_not;
  logic [0:0] h_not;
  logic       e_not;

  int n_chk = 0;
  int n_bad = 0;

  ncl_hyst_gate #(.FN(FN_AND), .LANES(2)) u_ncl_hyst_gate (
    .clk(clk), .rst_n(rst_n), .a_rails(a2), .b_rails(b2),
    .y_rails(y_and), .y_hold(h_and), .err(e_and));

  ncl_hyst_gate #(.FN(FN_OR), .LANES(2)) u_ncl_hyst_gate_or (
    .clk(clk), .rst_n(rst_n), .a_rails(a2), .b_rails(b2),
    .y_rails(y_or), .y_hold(h_or), .err(e_or));

  ncl_hyst_gate #(.FN(FN_NOT), .LANES(1)) u_ncl_hyst_gate_not (
    .clk(clk), .rst_n(rst_n), .a_rails(a1), .b_rails(b1),
    .y_rails(y_not), .y_hold(h_not), .err(e_not));

  // fields: a[7:6] b[5:4] expected AND[3:2] expected OR[1:0]
  // N=00 T=01 F=10 (R1); holds per R6 and R7, one edge per row (R8)
  localparam logic [7:0] VEC [15] = '{
    8'b01_00_00_00,  // partial data: stay NULL (R6)
    8'b01_01_01_01,
    8'b10_01_01_01,  // new data without NULL: hold (R7)
    8'b00_01_01_01,  // partial NULL: hold (R7)
    8'b00_00_00_00,
    8'b10_01_10_01,
    8'b00_00_00_00,
    8'b10_10_10_10,
    8'b00_10_10_10,
    8'b00_00_00_00,
    8'b01_10_10_01,
    8'b00_00_00_00,
    8'b00_10_00_00,
    8'b01_01_01_01,
    8'b00_00_00_00
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R2: complete data present while in reset
    a2 = 4'b0101; b2 = 4'b0101; a1 = 2'b01;
    repeat (3) step();
    chk("R2 and out", y_and, 0);
    chk("R2 or out", y_or, 0);
    chk("R2 hold", h_and, 0);
    chk("R2 err", e_and, 0);
    chk("R2 not out", y_not, 0);
    a2 = '0; b2 = '0; a1 = '0;
    step();
    rst_n = 1'b1;
    step();

    for (int i = 0; i < 15; i++) begin
      a2 = {2'b00, VEC[i][7:6]};
      b2 = {2'b00, VEC[i][5:4]};
      step();
      chk("R3 AND table", y_and[1:0], VEC[i][3:2]);
      chk("R4 OR table", y_or[1:0], VEC[i][1:0]);
      chk("R10 idle lane", y_and[3:2], 0);
    end

    // R8: no change before the sampling edge
    a2 = 4'b0001; b2 = 4'b0001;
    #1;
    chk("R8 before edge", y_and[1:0], 2'b00);
    step();
    chk("R8 after edge", y_and[1:0], 2'b01);
    chk("R11 hold set", h_and, 2'b01);
    // R7: multi-cycle partial NULL
    a2 = 4'b0000; b2 = 4'b0010;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R7 hold data", y_and[1:0], 2'b01);
    end
    b2 = 4'b0000;
    step();
    chk("R7 release", y_and[1:0], 2'b00);
    chk("R11 hold clear", h_and, 2'b00);

    // R6: multi-cycle partial data
    a2 = 4'b0001;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R6 stay NULL", y_and[1:0], 2'b00);
    end
    b2 = 4'b0010;
    step();
    chk("R1 FALSE code", y_and[1:0], 2'b10);
    a2 = '0; b2 = '0;
    step();

    // R9: illegal while NULL
    a2 = 4'b0011; b2 = 4'b0001;
    step();
    chk("R9 hold NULL", y_and[1:0], 2'b00);
    chk("R9 err set", e_and, 1);
    a2 = '0; b2 = '0;
    step();
    chk("R9 err clear", e_and, 0);
    // R9: illegal while DATA
    a2 = 4'b0001; b2 = 4'b0001;
    step();
    a2 = 4'b0011; b2 = 4'b0000;
    step();
    chk("R9 hold data", y_or[1:0], 2'b01);
    chk("R9 err set or", e_or, 1);
    a2 = '0;
    step();
    chk("R9 release", y_or[1:0], 2'b00);
    chk("R9 err clear or", e_or, 0);

    // R10: lanes driven differently
    a2 = 4'b0100; b2 = 4'b0101;
    step();
    chk("R10 lanes", y_and, 4'b0100);
    chk("R11 lane flags", h_and, 2'b10);
    a2 = '0; b2 = '0;
    step();

    // R5: NOT with b ignored
    b1 = 2'b01;
    step();
    chk("R5 b alone", y_not, 2'b00);
    a1 = 2'b01; b1 = 2'b11;
    step();
    chk("R5 not true", y_not, 2'b10);
    chk("R5 b illegal no err", e_not, 0);
    a1 = 2'b00; b1 = 2'b10;
    step();
    chk("R5 back to NULL", y_not, 2'b00);
    a1 = 2'b10; b1 = 2'b00;
    step();
    chk("R5 not false", y_not, 2'b01);
    a1 = 2'b00;
    step();
    chk("R5 final NULL", y_not, 2'b00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule